// File: doc/BRIEF.md
# Programmable Count-to-Limit Timer

This block is a 32-bit timer with three registers: a count, a limit and a control word. Software reaches them through a single-cycle register port. While its run bit is set, the count goes up by one on every clock. When the count equals the limit, the next count is zero. If interrupts are enabled at that wrap, a pending flag is set. The interrupt output is high while that flag is set and interrupts stay enabled.

Two instances can sit side by side and serve different roles. As an event timer, software writes a limit, writes zero to the count and turns on both run and interrupt enable. A control write is then the acknowledge: it clears the pending flag and can re-arm or stop the timer. As a free-running counter, the limit is set to all ones and interrupts stay off, so the count rises steadily and rolls over from the maximum value to zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the count, limit and control registers all read zero and `irq` is low.
- R2: Register address 0 is the count, 1 is the limit and 2 is the control word. Address 3 reads zero and a write to it changes nothing. The control word reads interrupt enable in bit 0, run in bit 1 and pending in bit 3, and every other bit reads zero.
- R3: While the run bit is clear, the count holds its value.
- R4: While the run bit is set, the count rises by exactly one on each clock.
- R5: On a clock where the count equals the limit and the timer runs, the count becomes zero. The period is therefore limit+1 clocks.
- R6: The pending bit is set at a wrap only if interrupt enable is 1 during that cycle. A wrap with interrupt enable at 0 leaves pending clear.
- R7: A control write updates only the enable and run bits and always clears pending. Writing a 1 to bit 3 never sets pending.
- R8: `irq` is high exactly when pending and interrupt enable are both set.
- R9: A count write loads any value. In the same cycle as a would-be wrap, the written value wins and pending is not set.
- R10: With the limit at 0xFFFFFFFF the count runs through 0xFFFFFFFE and 0xFFFFFFFF and then to 0, with no interrupt when enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port, one cycle per write |
| reg_addr | input | 2 | Register select: 0 count, 1 limit, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register that `reg_addr` selects, combinational |
| irq | output | 1 | Interrupt request, pending AND enable |

## Verification
The counting function is tried in four ways: halted, running below the limit, wrapping at a small limit with interrupts on and off, and rolling over at the all-ones limit. Comparing halted against running shows that the run bit gates the count. The small-limit runs show that the period is limit+1 and that the enable bit decides whether pending is set. Further stimulus overlaps a count write with a wrap, and writes a 1 to the pending bit position. These show that a count write takes priority over the wrap and that software can clear pending but cannot set it.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
// Package tick_timer_pkg
// Shared register selector codes and control-word bit positions for the
// count-to-limit timer. The bit positions are fixed because software
// decodes them.
package tick_timer_pkg;

    // Register selector on the single-cycle register port
    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Control-word bit positions
    localparam int CTRL_IE_BIT   = 0;
    localparam int CTRL_RUN_BIT  = 1;
    localparam int CTRL_PEND_BIT = 3;

    // Narrowest data width that still holds every control bit
    localparam int CTRL_MIN_W    = CTRL_PEND_BIT + 1;

    // Writable part of the control word
    typedef struct packed {
        logic run;
        logic ie;
    } ctrl_wr_t;

endpackage

// File: rtl/tick_timer_decode.sv
`timescale 1ns/1ps
// Module tick_timer_decode
// Turns the write strobe into one write enable per register and selects
// the read data. Reads have no side effects.
// Assumes: W >= CTRL_MIN_W, so every control bit has a place in the word.
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] count,
    input  logic [W-1:0] limit,
    input  logic         ie,
    input  logic         run,
    input  logic         pending,
    output logic         cnt_wr,
    output logic         lim_wr,
    output logic         ctl_wr,
    output logic [W-1:0] rdata
);

    logic [W-1:0] ctrl_word;

    // Per-register write enables from the strobe and the selector
    always_comb begin
        cnt_wr = wr && (reg_sel_e'(addr) == SEL_COUNT);
        lim_wr = wr && (reg_sel_e'(addr) == SEL_LIMIT);
        ctl_wr = wr && (reg_sel_e'(addr) == SEL_CTRL);
    end

    // Assemble the control word; the unused bits stay zero
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_IE_BIT]   = ie;
        ctrl_word[CTRL_RUN_BIT]  = run;
        ctrl_word[CTRL_PEND_BIT] = pending;
    end

    // Read data multiplexer; the free selector reads zero
    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_COUNT: rdata = count;
            SEL_LIMIT: rdata = limit;
            SEL_CTRL:  rdata = ctrl_word;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_core.sv
`timescale 1ns/1ps
// Module tick_timer_core
// Holds the count and limit registers and detects the wrap. While run is
// set the count rises by one each clock. When it equals the limit it goes
// to zero. A count write takes priority over both increment and wrap.
// Assumes: synchronous active-low reset; both registers reset to zero.
module tick_timer_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cnt_wr,
    input  logic         lim_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] limit,
    output logic         wrap
);

    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_nx;
    logic         at_limit;

    // Compare the count with the limit
    always_comb at_limit = (count == limit);

    // A wrap is reported only when the count is not being overwritten
    always_comb wrap = run && at_limit && !cnt_wr;

    // Next count: a write wins, then a wrap, then an increment, else hold
    always_comb begin
        if (cnt_wr)
            count_nx = wdata;
        else if (run && at_limit)
            count_nx = '0;
        else if (run)
            count_nx = count + STEP;
        else
            count_nx = count;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nx;
    end

    // Limit register, changed only by a bus write
    always_ff @(posedge clk) begin
        if (!rst_n)      limit <= '0;
        else if (lim_wr) limit <= wdata;
    end

endmodule

// File: rtl/tick_timer_ctrl.sv
`timescale 1ns/1ps
// Module tick_timer_ctrl
// Holds interrupt enable, run and the pending flag. A control write loads
// enable and run and always clears pending; the clear wins over a wrap in
// the same cycle. A wrap sets pending only if enable was set beforehand.
// Assumes: synchronous active-low reset; everything resets to zero.
module tick_timer_ctrl
    import tick_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_wr,
    input  ctrl_wr_t ctl_wdata,
    input  logic     wrap,
    output logic     ie,
    output logic     run,
    output logic     pending,
    output logic     irq
);

    // Enable and run bits, loaded by a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie  <= 1'b0;
            run <= 1'b0;
        end else if (ctl_wr) begin
            ie  <= ctl_wdata.ie;
            run <= ctl_wdata.run;
        end
    end

    // Pending flag: cleared by any control write, set by an enabled wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (ctl_wr)
            pending <= 1'b0;
        else if (wrap && ie)
            pending <= 1'b1;
    end

    // Interrupt request
    always_comb irq = pending && ie;

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
// Module tick_timer
// Top of the count-to-limit timer: register decode, count/limit core and
// control/interrupt logic. One instance is either an event timer or, with
// the limit at all ones, a free-running wrapping counter.
// Assumes: single-cycle register port; writes happen on the clock edge
// where reg_wr is high; reads are combinational and have no side effects.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         irq
);

    logic         cnt_wr;
    logic         lim_wr;
    logic         ctl_wr;
    logic [W-1:0] count_q;
    logic [W-1:0] limit_q;
    logic         wrap;
    logic         ie_q;
    logic         run_q;
    logic         pend_q;
    ctrl_wr_t     ctl_wdata;

    // Pick the writable control fields out of the write data
    always_comb begin
        ctl_wdata.ie  = reg_wdata[CTRL_IE_BIT];
        ctl_wdata.run = reg_wdata[CTRL_RUN_BIT];
    end

    tick_timer_decode #(.W(W)) u_decode (
        .wr      (reg_wr),
        .addr    (reg_addr),
        .count   (count_q),
        .limit   (limit_q),
        .ie      (ie_q),
        .run     (run_q),
        .pending (pend_q),
        .cnt_wr  (cnt_wr),
        .lim_wr  (lim_wr),
        .ctl_wr  (ctl_wr),
        .rdata   (reg_rdata)
    );

    tick_timer_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .cnt_wr (cnt_wr),
        .lim_wr (lim_wr),
        .wdata  (reg_wdata),
        .count  (count_q),
        .limit  (limit_q),
        .wrap   (wrap)
    );

    tick_timer_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .wrap      (wrap),
        .ie        (ie_q),
        .run       (run_q),
        .pending   (pend_q),
        .irq       (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
// Module tick_timer_chk
// Temporal checks on the timer, attached to tick_timer by bind.
module tick_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_wr,
    input logic         ctl_wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] count,
    input logic [W-1:0] limit,
    input logic         run,
    input logic         ie,
    input logic         pending,
    input logic         irq
);

    // R3
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr && count == limit) |=> (count == '0));

    // R9
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata)));

    // R6
    pend_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(ie) && $past(run) && !$past(cnt_wr)));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !pending);

    // R8
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pending && ie));

endmodule

bind tick_timer tick_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_wr  (cnt_wr),
    .ctl_wr  (ctl_wr),
    .wdata   (reg_wdata),
    .count   (count_q),
    .limit   (limit_q),
    .run     (run_q),
    .ie      (ie_q),
    .pending (pend_q),
    .irq     (irq)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
// Directed bench for tick_timer: one task per scenario.
module tick_timer_test;

    localparam int W = 32;
    localparam logic [1:0] A_CNT = 2'd0;
    localparam logic [1:0] A_LIM = 2'd1;
    localparam logic [1:0] A_CTL = 2'd2;
    localparam logic [1:0] A_NON = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         irq;

    int checks = 0;
    int fails = 0;

    tick_timer #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Write on the next edge; returns at the following falling edge
    task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Combinational read at the current falling edge
    task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd_reg(A_CNT, v); check("R1", "count after reset", v, 0);
        rd_reg(A_LIM, v); check("R1", "limit after reset", v, 0);
        rd_reg(A_CTL, v); check("R1", "ctrl after reset", v, 0);
        check("R1", "irq after reset", W'(irq), 0);
    endtask

    task automatic t_halted();
        logic [W-1:0] v;
        wr_reg(A_LIM, 32'd10);
        wr_reg(A_CNT, 32'd5);
        wait_clk(3);
        rd_reg(A_CNT, v); check("R3", "halted count", v, 32'd5);
        rd_reg(A_LIM, v); check("R2", "limit readback", v, 32'd10);
    endtask

    task automatic t_counting();
        logic [W-1:0] v;
        wr_reg(A_CNT, 32'd0);
        wr_reg(A_CTL, 32'h2);
        wait_clk(6);
        rd_reg(A_CNT, v); check("R4", "count after 6 clocks", v, 32'd6);
        wr_reg(A_CTL, 32'h0);
        wait_clk(2);
        rd_reg(A_CNT, v); check("R3", "count frozen after stop", v, 32'd7);
    endtask

    task automatic t_wrap_irq();
        logic [W-1:0] v;
        wr_reg(A_LIM, 32'd4);
        wr_reg(A_CNT, 32'd0);
        wr_reg(A_CTL, 32'h3);
        wait_clk(4);
        rd_reg(A_CNT, v); check("R5", "count at limit", v, 32'd4);
        rd_reg(A_CTL, v); check("R6", "ctrl before wrap", v, 32'h3);
        check("R8", "irq before wrap", W'(irq), 0);
        wait_clk(1);
        rd_reg(A_CNT, v); check("R5", "count after wrap", v, 32'd0);
        rd_reg(A_CTL, v); check("R6", "pending after enabled wrap", v, 32'hB);
        check("R8", "irq with pending and ie", W'(irq), 1);
        wait_clk(4);
        rd_reg(A_CNT, v); check("R5", "count one period later minus one", v, 32'd4);
        wait_clk(1);
        rd_reg(A_CNT, v); check("R5", "second wrap after limit+1", v, 32'd0);
        wr_reg(A_CTL, 32'h3);
        rd_reg(A_CTL, v); check("R7", "ack clears pending", v, 32'h3);
        check("R8", "irq low after ack", W'(irq), 0);
        rd_reg(A_CNT, v); check("R4", "count after ack", v, 32'd1);
    endtask

    task automatic t_no_ie();
        logic [W-1:0] v;
        wr_reg(A_CTL, 32'h0);
        wr_reg(A_CNT, 32'd0);
        wr_reg(A_LIM, 32'd2);
        wr_reg(A_CTL, 32'h2);
        wait_clk(3);
        rd_reg(A_CNT, v); check("R5", "wrap at limit 2", v, 32'd0);
        rd_reg(A_CTL, v); check("R6", "no pending without ie", v, 32'h2);
        check("R8", "irq low without ie", W'(irq), 0);
        wr_reg(A_CTL, 32'hFFFF_FFF8);
        rd_reg(A_CTL, v); check("R7", "bit 3 write cannot set pending", v, 32'h0);
        check("R7", "irq after bit 3 write", W'(irq), 0);
    endtask

    task automatic t_write_priority();
        logic [W-1:0] v;
        wr_reg(A_LIM, 32'd4);
        wr_reg(A_CNT, 32'd0);
        wr_reg(A_CTL, 32'h3);
        wait_clk(4);
        rd_reg(A_CNT, v); check("R9", "count at limit before write", v, 32'd4);
        wr_reg(A_CNT, 32'd2);
        rd_reg(A_CNT, v); check("R9", "written value wins over wrap", v, 32'd2);
        rd_reg(A_CTL, v); check("R9", "no pending from overridden wrap", v, 32'h3);
        check("R9", "irq after overridden wrap", W'(irq), 0);
    endtask

    task automatic t_free_run();
        logic [W-1:0] v;
        wr_reg(A_CTL, 32'h0);
        wr_reg(A_LIM, 32'hFFFF_FFFF);
        wr_reg(A_CNT, 32'hFFFF_FFFE);
        wr_reg(A_CTL, 32'h2);
        rd_reg(A_CNT, v); check("R10", "start value", v, 32'hFFFF_FFFE);
        wait_clk(1);
        rd_reg(A_CNT, v); check("R10", "maximum value", v, 32'hFFFF_FFFF);
        wait_clk(1);
        rd_reg(A_CNT, v); check("R10", "rolled over", v, 32'd0);
        rd_reg(A_CTL, v); check("R10", "no pending on rollover", v, 32'h2);
        wait_clk(3);
        rd_reg(A_CNT, v); check("R10", "keeps rising", v, 32'd3);
    endtask

    task automatic t_free_slot();
        logic [W-1:0] v;
        wr_reg(A_CTL, 32'h0);
        wr_reg(A_NON, 32'h1234_5678);
        rd_reg(A_NON, v); check("R2", "address 3 reads zero", v, 32'd0);
        rd_reg(A_LIM, v); check("R2", "limit unchanged by address 3", v, 32'hFFFF_FFFF);
        rd_reg(A_CNT, v); check("R2", "count unchanged by address 3", v, 32'd4);
        rd_reg(A_CTL, v); check("R2", "ctrl unchanged by address 3", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halted();
        t_counting();
        t_wrap_irq();
        t_no_ie();
        t_write_priority();
        t_free_run();
        t_free_slot();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule